// File: doc/BRIEF.md
# External Interrupt Broadcast Distributor

This block fans a set of external interrupt lines out to the cores of a cluster of up to 16 cores. For every interrupt line a routing mask selects which cores see that line. Each core's interrupt output vector carries, at bit position n, line n gated by that core's routing bit. The gating is combinational, so no cycle is added on the interrupt path.

Because one line can be routed to several cores at once, each line also has an ownership register that settles which core services it. Any core may try to take ownership. The first attempt made while the register shows the free pattern (all ones) stores a one-hot value naming that core. Later attempts leave the register unchanged. A core reads the register back, and if its own bit is clear it drops the interrupt. The owner frees the register by writing all ones once it has finished.

Every core has its own word-addressed register port: a write strobe, an address and write data, plus read data decoded from that core's address. Writes from several cores can land on the same register in one cycle. In that case the lowest-numbered core's write is the one that takes effect.

Top module: `irq_fanout`

## Requirements
- R1: Bit k*NIRQ+n of `core_irq` equals `irq_in[n]` ANDed with bit k of the routing mask of line n, with no clock delay.
- R2: After reset, the routing mask of every line has only bit 0 set, so only core 0 receives it.
- R3: After reset, every ownership register holds all ones (NCORE bits), which is the free pattern.
- R4: A write by core k to the ownership register of line n, with the low NCORE data bits not all ones, loads the one-hot value 1<<k if the register currently holds all ones.
- R5: Such an ownership attempt is ignored while the register does not hold all ones, and the register keeps its owner.
- R6: When several cores write the same register in one cycle, only the write of the lowest-numbered core takes effect. This applies to routing masks and ownership registers, and to a release competing with an attempt.
- R7: A write to an ownership register whose low NCORE data bits are all ones sets the register to all ones, whichever core performs it.
- R8: A write to the routing mask of line n loads the low NCORE data bits.
- R9: Routing masks sit at byte address 0x4000+4n and ownership registers at 0x8000+4n, for n < NIRQ. Reads return the value zero-extended to 32 bits. Any other address reads 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | NCORE | Per-core write strobe |
| addr | input | NCORE*16 | Per-core byte address, core k at bits [16k+15:16k] |
| wdata | input | NCORE*32 | Per-core write data, core k at bits [32k+31:32k] |
| rdata | output | NCORE*32 | Per-core read data for that core's address |
| irq_in | input | NIRQ | External interrupt lines |
| core_irq | output | NCORE*NIRQ | Per-core interrupt vectors, core k at bits [NIRQ*k+NIRQ-1:NIRQ*k] |

## Verification
The fan-out is driven with these line patterns:
- All lines high, under the reset masks. This shows that only core 0 is routed after reset.
- A single line with a two-core mask. This separates core positions within the output vector.
- Walking-one lines over distinct per-line masks. These catch a swapped line or core index.

Ownership is exercised with:
- An attempt on a free register.
- An attempt on a held register.
- Two simultaneous attempts.
- A release racing an attempt.
- A release by a core that does not own the register.

A long run of random multi-core writes and random line values is then compared against a behavioural model on every clock.

// File: rtl/irq_fanout.sv
module irq_fanout #(
  parameter int NCORE = 4,
  parameter int NIRQ  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCORE-1:0]      wr_en,
  input  logic [NCORE*16-1:0]   addr,
  input  logic [NCORE*32-1:0]   wdata,
  output logic [NCORE*32-1:0]   rdata,
  input  logic [NIRQ-1:0]       irq_in,
  output logic [NCORE*NIRQ-1:0] core_irq
);
  localparam int AW = 16;
  localparam int DW = 32;
  localparam logic [AW-1:0] MASK_BASE = 16'h4000;
  localparam logic [AW-1:0] OWN_BASE  = 16'h8000;

  logic [NIRQ-1:0][NCORE-1:0] route_q;
  logic [NIRQ-1:0][NCORE-1:0] own_q;

  for (genvar n = 0; n < NIRQ; n++) begin : g_line
    logic             mask_hit, own_hit;
    logic [NCORE-1:0] mask_val, own_val, own_who;

    always_comb begin
      mask_hit = 1'b0;
      mask_val = '0;
      own_hit  = 1'b0;
      own_val  = '0;
      own_who  = '0;
      for (int k = NCORE - 1; k >= 0; k--) begin
        if (wr_en[k] && addr[k*AW +: AW] == MASK_BASE + AW'(4 * n)) begin
          mask_hit = 1'b1;
          mask_val = wdata[k*DW +: NCORE];
        end
        if (wr_en[k] && addr[k*AW +: AW] == OWN_BASE + AW'(4 * n)) begin
          own_hit = 1'b1;
          own_val = wdata[k*DW +: NCORE];
          own_who = NCORE'(1) << k;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        route_q[n] <= NCORE'(1);
        own_q[n]   <= '1;
      end else begin
        if (mask_hit) route_q[n] <= mask_val;
        if (own_hit) begin
          if (&own_val)        own_q[n] <= '1;
          else if (&own_q[n])  own_q[n] <= own_who;
        end
      end
    end
  end

  for (genvar k = 0; k < NCORE; k++) begin : g_core
    logic [DW-1:0] rd;

    for (genvar n = 0; n < NIRQ; n++) begin : g_out
      assign core_irq[k*NIRQ + n] = irq_in[n] & route_q[n][k];
    end

    always_comb begin
      rd = '0;
      for (int n = 0; n < NIRQ; n++) begin
        if (addr[k*AW +: AW] == MASK_BASE + AW'(4 * n)) rd = DW'(route_q[n]);
        if (addr[k*AW +: AW] == OWN_BASE + AW'(4 * n))  rd = DW'(own_q[n]);
      end
    end

    assign rdata[k*DW +: DW] = rd;
  end
endmodule

module irq_fanout_chk #(
  parameter int NCORE = 4,
  parameter int NIRQ  = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NCORE-1:0]           wr_en,
  input logic [NCORE*16-1:0]        addr,
  input logic [NCORE*32-1:0]        wdata,
  input logic [NIRQ-1:0]            irq_in,
  input logic [NCORE*NIRQ-1:0]      core_irq,
  input logic [NIRQ-1:0][NCORE-1:0] own_q
);
  for (genvar n = 0; n < NIRQ; n++) begin : g_chk
    logic             rel_any, c0_try, c0_rel;
    logic [NCORE-1:0] line_out;

    always_comb begin
      rel_any = 1'b0;
      for (int k = 0; k < NCORE; k++)
        if (wr_en[k] && addr[k*16 +: 16] == 16'h8000 + 16'(4 * n) && &wdata[k*32 +: NCORE])
          rel_any = 1'b1;
      for (int k = 0; k < NCORE; k++) line_out[k] = core_irq[k*NIRQ + n];
    end

    assign c0_try = wr_en[0] && addr[15:0] == 16'h8000 + 16'(4 * n) && !(&wdata[NCORE-1:0]);
    assign c0_rel = wr_en[0] && addr[15:0] == 16'h8000 + 16'(4 * n) && (&wdata[NCORE-1:0]);

    // R1
    idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_in[n] |-> line_out == '0);
    // R4
    own_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (&own_q[n]) || $onehot(own_q[n]));
    // R4
    first_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (&own_q[n]) && c0_try |=> own_q[n] == NCORE'(1));
    // R5
    held_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(&own_q[n]) && !rel_any |=> $stable(own_q[n]));
    // R7
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      c0_rel |=> &own_q[n]);
  end
endmodule

bind irq_fanout irq_fanout_chk #(.NCORE(NCORE), .NIRQ(NIRQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .irq_in(irq_in), .core_irq(core_irq), .own_q(own_q)
);

// File: tb/irq_fanout_test.sv
module irq_fanout_test;
  localparam int NCORE = 4;
  localparam int NIRQ  = 8;
  localparam logic [NCORE-1:0] FREE = '1;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic [NCORE-1:0]      wr_en = '0;
  logic [NCORE*16-1:0]   addr = '0;
  logic [NCORE*32-1:0]   wdata = '0;
  logic [NCORE*32-1:0]   rdata;
  logic [NIRQ-1:0]       irq_in = '0;
  logic [NCORE*NIRQ-1:0] core_irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [NCORE-1:0] m_route [NIRQ];
  logic [NCORE-1:0] m_own   [NIRQ];

  irq_fanout #(.NCORE(NCORE), .NIRQ(NIRQ)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq_in(irq_in), .core_irq(core_irq)
  );

  always #10 clk = ~clk;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(logic [15:0] a);
    model_read = '0;
    for (int n = 0; n < NIRQ; n++) begin
      if (a == 16'h4000 + 16'(4 * n)) model_read = 32'(m_route[n]);
      if (a == 16'h8000 + 16'(4 * n)) model_read = 32'(m_own[n]);
    end
  endfunction

  task automatic model_step();
    for (int n = 0; n < NIRQ; n++) begin
      if (!rst_n) begin
        m_route[n] = NCORE'(1);
        m_own[n]   = FREE;
      end else begin
        bit mdone = 0;
        bit odone = 0;
        for (int k = 0; k < NCORE; k++) begin
          logic [15:0] a = addr[k*16 +: 16];
          logic [NCORE-1:0] d = wdata[k*32 +: NCORE];
          if (wr_en[k] && !mdone && a == 16'h4000 + 16'(4 * n)) begin
            mdone = 1;
            m_route[n] = d;
          end
          if (wr_en[k] && !odone && a == 16'h8000 + 16'(4 * n)) begin
            odone = 1;
            if (d == FREE) m_own[n] = FREE;
            else if (m_own[n] == FREE) m_own[n] = NCORE'(1) << k;
          end
        end
      end
    end
  endtask

  task automatic cyc();
    logic [NCORE*NIRQ-1:0] exp_irq;
    @(posedge clk);
    model_step();
    @(negedge clk);
    for (int k = 0; k < NCORE; k++)
      for (int n = 0; n < NIRQ; n++)
        exp_irq[k*NIRQ + n] = irq_in[n] & m_route[n][k];
    chk("R1 core_irq", 64'(core_irq), 64'(exp_irq));
    for (int k = 0; k < NCORE; k++)
      chk("R9 rdata", 64'(rdata[k*32 +: 32]), 64'(model_read(addr[k*16 +: 16])));
  endtask

  task automatic put(int k, logic [15:0] a, logic [31:0] d);
    wr_en[k] = 1'b1;
    addr[k*16 +: 16] = a;
    wdata[k*32 +: 32] = d;
  endtask

  task automatic idle();
    wr_en = '0;
  endtask

  task automatic look(int k, logic [15:0] a);
    wr_en = '0;
    addr[k*16 +: 16] = a;
    cyc();
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) begin
      @(posedge clk);
      model_step();
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R2 R3: reset values read back
    for (int n = 0; n < NIRQ; n++) begin
      look(0, 16'h4000 + 16'(4 * n));
      chk("R2 reset mask", 64'(rdata[31:0]), 64'h1);
      look(0, 16'h8000 + 16'(4 * n));
      chk("R3 reset owner", 64'(rdata[31:0]), 64'hF);
    end

    // R1 R2: all lines high, only core 0 routed
    irq_in = '1;
    cyc();
    chk("R1 R2 reset routing", 64'(core_irq), 64'h0000_00FF);

    // R8: two-core mask on line 3
    put(1, 16'h400C, 32'hFFFF_FFF6);
    cyc();
    idle();
    look(1, 16'h400C);
    chk("R8 mask write", 64'(rdata[63:32]), 64'h6);
    irq_in = 8'h08;
    cyc();
    chk("R1 single line", 64'(core_irq), 64'((1 << 11) | (1 << 19)));

    // R8 R1: distinct masks, walking one
    for (int n = 0; n < NIRQ; n++) begin
      put(n % NCORE, 16'h4000 + 16'(4 * n), 32'((n * 5 + 3) % 16));
      cyc();
      idle();
    end
    for (int n = 0; n < NIRQ; n++) begin
      irq_in = NIRQ'(1) << n;
      cyc();
    end
    irq_in = 8'hA5;
    cyc();

    // R6: simultaneous mask writes, lower core wins
    put(3, 16'h4000, 32'h8);
    put(2, 16'h4000, 32'h4);
    cyc();
    idle();
    look(0, 16'h4000);
    chk("R6 mask race", 64'(rdata[31:0]), 64'h4);

    // R4: take a free owner register
    put(2, 16'h8004, 32'h4);
    cyc();
    idle();
    look(0, 16'h8004);
    chk("R4 first take", 64'(rdata[31:0]), 64'h4);

    // R5: attempt while held is ignored
    put(0, 16'h8004, 32'h1);
    cyc();
    idle();
    look(0, 16'h8004);
    chk("R5 held ignore", 64'(rdata[31:0]), 64'h4);

    // R7: owner releases
    put(2, 16'h8004, 32'hFFFF_FFFF);
    cyc();
    idle();
    look(0, 16'h8004);
    chk("R7 release", 64'(rdata[31:0]), 64'hF);

    // R6: two simultaneous attempts, lower wins
    put(3, 16'h8004, 32'h8);
    put(1, 16'h8004, 32'h2);
    cyc();
    idle();
    look(0, 16'h8004);
    chk("R6 take race", 64'(rdata[31:0]), 64'h2);

    // R6: lower core's ignored attempt beats a higher core's release
    put(0, 16'h8004, 32'h1);
    put(3, 16'h8004, 32'hFFFF_FFFF);
    cyc();
    idle();
    look(0, 16'h8004);
    chk("R6 release race", 64'(rdata[31:0]), 64'h2);

    // R7: release by a non-owner
    put(3, 16'h8004, 32'hFFFF_FFFF);
    cyc();
    idle();
    look(0, 16'h8004);
    chk("R7 foreign release", 64'(rdata[31:0]), 64'hF);

    // R9: unmapped and misaligned writes ignored, reads return 0
    put(0, 16'h4000 + 16'(4 * NIRQ), 32'h0);
    put(1, 16'h4002, 32'h0);
    put(2, 16'h8001, 32'h0);
    cyc();
    idle();
    look(0, 16'h4000);
    chk("R9 misaligned ignored", 64'(rdata[31:0]), 64'h4);
    look(0, 16'h8000);
    chk("R9 claim untouched", 64'(rdata[31:0]), 64'hF);
    look(0, 16'h4000 + 16'(4 * NIRQ));
    chk("R9 out of range", 64'(rdata[31:0]), 64'h0);
    look(0, 16'h1234);
    chk("R9 unmapped", 64'(rdata[31:0]), 64'h0);

    // Random multi-core traffic against the model (R1 R4 R5 R6 R7 R8 R9)
    for (int i = 0; i < 2000; i++) begin
      for (int k = 0; k < NCORE; k++) begin
        int n = int'($urandom % NIRQ);
        logic [15:0] base = ($urandom % 2 == 0) ? 16'h4000 : 16'h8000;
        wr_en[k] = ($urandom % 3 == 0);
        addr[k*16 +: 16] = base + 16'(4 * n);
        wdata[k*32 +: 32] = ($urandom % 4 == 0) ? 32'hFFFF_FFFF : $urandom;
      end
      irq_in = NIRQ'($urandom);
      cyc();
    end
    idle();

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule